// File: doc/BRIEF.md
# Accumulator Half-LSB Rounding Stage

This stage rounds a 40-bit accumulator word so that its upper 24 bits (bits 39:16) form the rounded result. It sits behind a multiplier-accumulator datapath. It can take the output of a multiply, a multiply-add or a multiply-subtract. It can also take a stored accumulator on its own, which gives a round-and-transfer operation. Any upstream product formatting is done before the value reaches this stage, including signed operand handling and the one-bit left shift in fractional mode.

Rounding adds one at bit 15. A mode input selects one of two behaviours:

- **Round-to-even (mode 0, the default):** on an exact tie, where the low half is 0x8000, bit 16 of the sum is then cleared.
- **Round-half-up (mode 1):** the tie is left as summed.

In both modes the low 16 bits are carried through from the sum and are never zeroed. When rounding is not enabled, the word passes through unchanged. An overflow flag reports whether the registered output has spilled past the 32-bit signed range. The result appears one clock after the inputs.

Top module: `acc_rnd_stage`

## Requirements
- R1: While `rst` is high at a clock edge, the next `acc_out` is 0 and `acc_ovf` is 0.
- R2: With `rnd_en` low, `acc_out` one cycle later equals the `acc_in` of the previous cycle, and `rnd_mode` has no effect on it.
- R3: With `rnd_en` high, `acc_out` one cycle later equals `acc_in + 0x8000` modulo 2^40, except as changed by R4.
- R4: With `rnd_en` high, `rnd_mode` = 0 and `acc_in[15:0]` = 0x8000, bit 16 of the result is forced to 0. For example, 00_0000_8000 becomes 00_0000_0000 and 00_0001_8000 becomes 00_0002_0000.
- R5: With `rnd_en` high, `rnd_mode` = 1 and `acc_in[15:0]` = 0x8000, nothing is forced. For example, 00_0000_8000 becomes 00_0001_0000.
- R6: When `acc_in[15:0]` differs from 0x8000, both modes give the same result. For example, 00_0000_8001 becomes 00_0001_0001 and 00_0000_7FFF becomes 00_0000_FFFF.
- R7: `acc_ovf` is 1 exactly when bits 39:31 of the current `acc_out` are neither all zeros nor all ones.
- R8: When rounding is enabled, the output's low 16 bits equal the previous input's low 16 bits with bit 15 inverted; they are not cleared.
- R9: The increment wraps at the top of the word, so 7F_FFFF_8000 rounds to 80_0000_0000 with `acc_ovf` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_in | input | 40 | Accumulator word to round |
| rnd_mode | input | 1 | 0 = round-to-even, 1 = round-half-up |
| rnd_en | input | 1 | 1 = round, 0 = pass through |
| acc_out | output | 40 | Registered result |
| acc_ovf | output | 1 | Overflow flag of `acc_out` |

## Verification
The assertions run on every cycle. They check the following:
- the reset value;
- pass-through when rounding is off;
- the tie clearing of bit 16 in round-to-even mode;
- the bit-15 inversion of the low half;
- the agreement of the overflow flag with the output's top nine bits.

The full 40-bit arithmetic needs the bench's scenarios. These cover the tie table values in both modes, negative ties and wrap-around at the top of the word. They also include random words with forced tie patterns. Each expected word is computed from a separate half-to-even model on the upper 24 bits.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;
    localparam int ACC_W  = 40;   // accumulator width
    localparam int LOW_W  = 16;   // bits below the rounding boundary
    localparam int SPAN_W = 9;    // top bits that must agree for no overflow

    localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (LOW_W - 1);
    localparam logic [LOW_W-1:0] TIE_PAT  = LOW_W'(1) << (LOW_W - 1);

    typedef logic [ACC_W-1:0] acc_t;

    typedef enum logic {
        RND_EVEN = 1'b0,
        RND_UP   = 1'b1
    } rnd_mode_e;

    typedef struct packed {
        acc_t value;
        logic ovf;
    } rnd_out_t;

    function automatic logic span_breach(input acc_t v);
        logic [SPAN_W-1:0] top;
        top = v[ACC_W-1 -: SPAN_W];
        return !((&top) || (~|top));
    endfunction
endpackage

// File: rtl/acc_rnd_inc.sv
module acc_rnd_inc
    import acc_rnd_pkg::*;
(
    input  acc_t a,
    input  logic en,
    output acc_t sum,
    output logic tie
);
    always_comb begin
        sum = en ? (a + HALF_LSB) : a;
        tie = en && (a[LOW_W-1:0] == TIE_PAT);
    end
endmodule

// File: rtl/acc_rnd_tie.sv
module acc_rnd_tie
    import acc_rnd_pkg::*;
(
    input  acc_t      sum,
    input  logic      tie,
    input  rnd_mode_e mode,
    output acc_t      fixed
);
    always_comb begin
        fixed = sum;
        if (tie && (mode == RND_EVEN))
            fixed[LOW_W] = 1'b0;
    end
endmodule

// File: rtl/acc_rnd_ovf.sv
module acc_rnd_ovf
    import acc_rnd_pkg::*;
(
    input  acc_t v,
    output logic ovf
);
    always_comb ovf = span_breach(v);
endmodule

// File: rtl/acc_rnd_stage.sv
module acc_rnd_stage
    import acc_rnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             rnd_mode,
    input  logic             rnd_en,
    output logic [ACC_W-1:0] acc_out,
    output logic             acc_ovf
);
    acc_t     inc_sum;
    logic     inc_tie;
    acc_t     fixed_val;
    logic     next_ovf;
    rnd_out_t res_q;

    acc_rnd_inc u_inc (
        .a   (acc_in),
        .en  (rnd_en),
        .sum (inc_sum),
        .tie (inc_tie)
    );

    acc_rnd_tie u_tie (
        .sum   (inc_sum),
        .tie   (inc_tie),
        .mode  (rnd_mode_e'(rnd_mode)),
        .fixed (fixed_val)
    );

    acc_rnd_ovf u_ovf (
        .v   (fixed_val),
        .ovf (next_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.value <= fixed_val;
            res_q.ovf   <= next_ovf;
        end
    end

    assign acc_out = res_q.value;
    assign acc_ovf = res_q.ovf;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !acc_ovf));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        !rnd_en |=> acc_out == $past(acc_in));

    // R4
    tie_even_chk: assert property (@(posedge clk) disable iff (rst)
        (rnd_en && !rnd_mode && acc_in[LOW_W-1:0] == TIE_PAT)
        |=> (!acc_out[LOW_W] && acc_out[LOW_W-1:0] == '0));

    // R8
    low_keep_chk: assert property (@(posedge clk) disable iff (rst)
        rnd_en |=> acc_out[LOW_W-1:0] == ($past(acc_in[LOW_W-1:0]) ^ TIE_PAT));

    // R7
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        acc_ovf == !((&acc_out[ACC_W-1 -: SPAN_W]) || (~|acc_out[ACC_W-1 -: SPAN_W])));
endmodule

// File: tb/acc_rnd_stage_bench.sv
`timescale 1ns/1ps
module acc_rnd_stage_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [39:0] acc_in;
    logic        rnd_mode;
    logic        rnd_en;
    logic [39:0] acc_out;
    logic        acc_ovf;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    acc_rnd_stage u_acc_rnd_stage (
        .clk      (clk),
        .rst      (rst),
        .acc_in   (acc_in),
        .rnd_mode (rnd_mode),
        .rnd_en   (rnd_en),
        .acc_out  (acc_out),
        .acc_ovf  (acc_ovf)
    );

    // half-to-even / half-up model on the upper 24 bits
    function automatic logic [39:0] ref_round(logic [39:0] x, logic mode, logic en);
        logic [23:0] up;
        logic [15:0] lo;
        if (!en) return x;
        up = x[39:16];
        lo = x[15:0];
        if (lo > 16'h8000 || (lo == 16'h8000 && (mode || up[0])))
            up = up + 24'd1;
        return {up, lo ^ 16'h8000};
    endfunction

    function automatic logic ref_ovf(logic [39:0] v);
        return !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
    endfunction

    task automatic apply(input logic [39:0] x, input logic mode, input logic en,
                         input string req);
        logic [39:0] exp_v;
        logic        exp_o;
        @(negedge clk);
        acc_in   = x;
        rnd_mode = mode;
        rnd_en   = en;
        exp_v    = ref_round(x, mode, en);
        exp_o    = ref_ovf(exp_v);
        @(posedge clk);
        #1;
        checks++;
        if (acc_out !== exp_v || acc_ovf !== exp_o) begin
            errors++;
            $display("FAIL %s: in=%h mode=%0d en=%0d actual=%h/%0d expected=%h/%0d",
                     req, x, mode, en, acc_out, acc_ovf, exp_v, exp_o);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [39:0] r;
        void'($urandom(32'd1357));
        rst = 1'b1; acc_in = 40'h12_3456_8000; rnd_mode = 1'b0; rnd_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (acc_out !== 40'd0 || acc_ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual=%h/%0d expected=0/0", acc_out, acc_ovf);
        end
        @(negedge clk);
        rst = 1'b0;

        // R4 R5 table ties
        apply(40'h00_0000_8000, 1'b1, 1'b1, "R5");
        apply(40'h00_0000_8000, 1'b0, 1'b1, "R4");
        apply(40'h00_0001_8000, 1'b1, 1'b1, "R5");
        apply(40'h00_0001_8000, 1'b0, 1'b1, "R4");
        // R6 non-ties, both modes
        apply(40'h00_0000_8001, 1'b0, 1'b1, "R6");
        apply(40'h00_0000_8001, 1'b1, 1'b1, "R6");
        apply(40'h00_0000_7FFF, 1'b0, 1'b1, "R6");
        apply(40'h00_0000_7FFF, 1'b1, 1'b1, "R6");
        apply(40'h00_0001_8001, 1'b0, 1'b1, "R6");
        apply(40'h00_0001_7FFF, 1'b1, 1'b1, "R6");
        // R3 R4 negative tie and carry rippling into the sign
        apply(40'hFF_FFFF_8000, 1'b0, 1'b1, "R4");
        apply(40'hFF_FFFF_8000, 1'b1, 1'b1, "R3");
        // R9 R7 wrap and overflow
        apply(40'h7F_FFFF_8000, 1'b1, 1'b1, "R9");
        apply(40'hFF_FFFF_FFFF, 1'b0, 1'b1, "R9");
        apply(40'h00_7FFF_8000, 1'b1, 1'b1, "R7");
        apply(40'h00_7FFF_7FFF, 1'b1, 1'b1, "R7");
        apply(40'hFF_8000_0000, 1'b0, 1'b1, "R7");
        // R2 pass-through, mode ignored, tie pattern untouched
        apply(40'h00_0000_8000, 1'b0, 1'b0, "R2");
        apply(40'h00_0000_8000, 1'b1, 1'b0, "R2");
        apply(40'h3A_5A5A_1234, 1'b0, 1'b0, "R2");
        // random mix, some with forced tie patterns (R3 R8)
        for (int i = 0; i < 400; i++) begin
            r = {8'($urandom()), 32'($urandom())};
            if ($urandom_range(0, 3) == 0) r[15:0] = 16'h8000;
            if ($urandom_range(0, 3) == 0) r[39:31] = {9{r[30]}};
            apply(r, 1'($urandom()), ($urandom_range(0, 4) != 0), "R3");
        end
        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1; acc_in = 40'h7F_FFFF_FFFF; rnd_en = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (acc_out !== 40'd0 || acc_ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual=%h/%0d expected=0/0", acc_out, acc_ovf);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule